// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two levels of translation tables from memory. A request carries the linear address, a write flag and a user flag. When the walker accepts it, it also latches the page that holds the directory. The walker then fetches one directory word. That word locates a page of table words, and the walker fetches one table word from it. The table word supplies the physical frame, and the page offset is appended to it.

Access rights are checked at each level as its word comes back. An entry with its present bit clear stops the walk. A user access needs the user-allowed bit set at both levels. A user write also needs the writable bit set at both levels. Supervisor accesses are never refused for rights. Each walk ends with a single-cycle completion pulse. That pulse carries either the physical address or a fault, with a cause code and the level where the fault was detected. Memory is reached through a read port that allows one request at a time: a valid/ready request phase, followed by a single response word.

Top module: `pgw_walker`

## Requirements
- R1: The walker accepts a request only while `req_ready` is high. `req_ready` is high exactly when no walk is in progress. The first memory read goes to `{dir_base[31:12], lin[31:22], 2'b00}`, using the `dir_base` value latched at acceptance.
- R2: After a directory word `D` that passes its checks, the second read goes to `{D[31:12], lin[21:12], 2'b00}`.
- R3: On success, `phys_addr = {T[31:12], lin[11:0]}`, where `T` is the table word, and `fault` is 0.
- R4: Entry bit 0 is present. A directory word with bit 0 clear ends the walk with `fault=1`, `fault_cause=2'b01` and `fault_level=0`. No table read is issued in that case.
- R5: A table word with bit 0 clear ends the walk with `fault=1`, `fault_cause=2'b01` and `fault_level=1`.
- R6: Entry bit 2 allows user access. A user request fails with `fault_cause=2'b11` at the first level whose word has bit 2 clear. This cause takes priority over a write refusal at the same level.
- R7: Entry bit 1 allows writes. A user write fails with `fault_cause=2'b10` at the first level whose word has bit 1 clear, once the earlier checks have passed.
- R8: A supervisor request (`req_user=0`) ignores bits 1 and 2 at both levels. Only the present bits can fault it.
- R9: While a walk is in progress, the values on the request inputs have no effect on its result.
- R10: `done` is high for exactly one cycle per walk, both on success and on fault. On success `fault_cause` is `2'b00`.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new request is issued before the response word arrives.
- R12: After reset, `req_ready=1`, `done=0` and `mem_req_valid=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Physical address of the directory page (low 12 bits unused) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Response word present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 00 none, 01 not present, 10 write refused, 11 user refused |
| fault_level | output | 1 | 0 directory, 1 table |
| phys_addr | output | 32 | Translated physical address |

## Verification
The hardest case to reach from the ports is a table-level rights fault caused only by the AND of the two levels. In that case the directory word passes on its own and the table word alone would refuse the access. To reach it, the bench builds the table memory for each walk. It draws the attribute bits of both words independently, with the present bits biased high, and places the table word at the address that the chosen directory word points to. Directed walks add the cases where both a user refusal and a write refusal apply at once.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_RD_DIR, ST_WT_DIR, ST_RD_TBL, ST_WT_TBL, ST_FIN
   } pgw_state_t;

   typedef enum logic [1:0] {
      FC_NONE   = 2'b00,
      FC_ABSENT = 2'b01,
      FC_WPROT  = 2'b10,
      FC_PRIV   = 2'b11
   } pgw_cause_t;

   localparam int unsigned BIT_PRESENT = 0;
   localparam int unsigned BIT_WRITE   = 1;
   localparam int unsigned BIT_USER    = 2;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
   parameter int unsigned LA_W  = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned IDX_W = 10,
   parameter int unsigned OFF_W = 12
) (
   input  logic [LA_W-1:0]       lin,
   input  logic [PA_W-OFF_W-1:0] dir_frame,
   input  logic [PA_W-OFF_W-1:0] tbl_frame,
   output logic [PA_W-1:0]       dir_addr,
   output logic [PA_W-1:0]       tbl_addr,
   output logic [OFF_W-1:0]      offset
);
   localparam int unsigned TBL_LO = OFF_W;
   localparam int unsigned DIR_LO = OFF_W + IDX_W;
   localparam int unsigned PAD_W  = PA_W - (PA_W - OFF_W) - IDX_W;

   logic [IDX_W-1:0] dir_idx;
   logic [IDX_W-1:0] tbl_idx;

   assign dir_idx  = lin[DIR_LO +: IDX_W];
   assign tbl_idx  = lin[TBL_LO +: IDX_W];
   assign offset   = lin[OFF_W-1:0];
   assign dir_addr = {dir_frame, dir_idx, {PAD_W{1'b0}}};
   assign tbl_addr = {tbl_frame, tbl_idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/pgw_check.sv
module pgw_check
   import pgw_pkg::*;
#(
   parameter int unsigned ENT_W = 32
) (
   input  logic [ENT_W-1:0] entry,
   input  logic             up_write,
   input  logic             up_user,
   input  logic             acc_write,
   input  logic             acc_user,
   output pgw_cause_t       cause
);
   logic eff_write;
   logic eff_user;

   assign eff_write = entry[BIT_WRITE] & up_write;
   assign eff_user  = entry[BIT_USER]  & up_user;

   always_comb begin
      if (!entry[BIT_PRESENT])                   cause = FC_ABSENT;
      else if (acc_user && !eff_user)            cause = FC_PRIV;
      else if (acc_user && acc_write && !eff_write) cause = FC_WPROT;
      else                                       cause = FC_NONE;
   end
endmodule

// File: rtl/pgw_fsm.sv
module pgw_fsm
   import pgw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       mem_req_ready,
   input  logic       mem_rsp_valid,
   input  logic       stop_walk,
   output pgw_state_t state
);
   pgw_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:   if (req_valid)     nxt = ST_RD_DIR;
         ST_RD_DIR: if (mem_req_ready) nxt = ST_WT_DIR;
         ST_WT_DIR: if (mem_rsp_valid) nxt = stop_walk ? ST_FIN : ST_RD_TBL;
         ST_RD_TBL: if (mem_req_ready) nxt = ST_WT_TBL;
         ST_WT_TBL: if (mem_rsp_valid) nxt = ST_FIN;
         ST_FIN:                       nxt = ST_IDLE;
         default:                      nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
   import pgw_pkg::*;
#(
   parameter int unsigned LA_W  = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned IDX_W = 10,
   parameter int unsigned OFF_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [LA_W-1:0] req_lin,
   input  logic            req_write,
   input  logic            req_user,
   input  logic [PA_W-1:0] dir_base,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [PA_W-1:0] mem_rsp_data,
   output logic            done,
   output logic            fault,
   output logic [1:0]      fault_cause,
   output logic            fault_level,
   output logic [PA_W-1:0] phys_addr
);
   localparam int unsigned FRM_W = PA_W - OFF_W;

   if (LA_W != 2 * IDX_W + OFF_W) begin : g_bad_split
      $error("pgw_walker: LA_W must equal 2*IDX_W+OFF_W");
   end
   if (OFF_W != IDX_W + 2) begin : g_bad_entry
      $error("pgw_walker: a table page must hold 2**IDX_W words");
   end
   if (OFF_W < 3) begin : g_bad_attr
      $error("pgw_walker: OFF_W too small for attribute bits");
   end

   pgw_state_t        state;
   logic [LA_W-1:0]   lin_q;
   logic              wr_q, usr_q;
   logic [FRM_W-1:0]  base_q;
   logic [FRM_W-1:0]  pde_frm_q;
   logic              pde_wr_q, pde_usr_q;
   logic [PA_W-1:0]   dir_addr, tbl_addr;
   logic [OFF_W-1:0]  offset;
   logic              at_tbl, rsp_dir, rsp_tbl, accept;
   pgw_cause_t        cause;

   assign at_tbl  = (state == ST_WT_TBL);
   assign rsp_dir = (state == ST_WT_DIR) && mem_rsp_valid;
   assign rsp_tbl = at_tbl && mem_rsp_valid;
   assign accept  = req_valid && req_ready;

   pgw_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .stop_walk     (cause != FC_NONE),
      .state         (state)
   );

   pgw_addr #(.LA_W(LA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
      .lin       (lin_q),
      .dir_frame (base_q),
      .tbl_frame (pde_frm_q),
      .dir_addr  (dir_addr),
      .tbl_addr  (tbl_addr),
      .offset    (offset)
   );

   pgw_check #(.ENT_W(PA_W)) u_check (
      .entry     (mem_rsp_data),
      .up_write  (at_tbl ? pde_wr_q  : 1'b1),
      .up_user   (at_tbl ? pde_usr_q : 1'b1),
      .acc_write (wr_q),
      .acc_user  (usr_q),
      .cause     (cause)
   );

   assign req_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_RD_DIR) || (state == ST_RD_TBL);
   assign mem_req_addr  = (state == ST_RD_TBL) ? tbl_addr : dir_addr;
   assign done          = (state == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lin_q     <= '0;
         wr_q      <= 1'b0;
         usr_q     <= 1'b0;
         base_q    <= '0;
         pde_frm_q <= '0;
         pde_wr_q  <= 1'b0;
         pde_usr_q <= 1'b0;
      end else if (accept) begin
         lin_q  <= req_lin;
         wr_q   <= req_write;
         usr_q  <= req_user;
         base_q <= dir_base[PA_W-1:OFF_W];
      end else if (rsp_dir) begin
         pde_frm_q <= mem_rsp_data[PA_W-1:OFF_W];
         pde_wr_q  <= mem_rsp_data[BIT_WRITE];
         pde_usr_q <= mem_rsp_data[BIT_USER];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault       <= 1'b0;
         fault_cause <= FC_NONE;
         fault_level <= 1'b0;
         phys_addr   <= '0;
      end else if (accept) begin
         fault       <= 1'b0;
         fault_cause <= FC_NONE;
         fault_level <= 1'b0;
      end else if ((rsp_dir || rsp_tbl) && cause != FC_NONE) begin
         fault       <= 1'b1;
         fault_cause <= cause;
         fault_level <= at_tbl;
      end else if (rsp_tbl) begin
         phys_addr <= {mem_rsp_data[PA_W-1:OFF_W], offset};
      end
   end
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
   parameter int unsigned LA_W  = 32,
   parameter int unsigned PA_W  = 32,
   parameter int unsigned OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [LA_W-1:0] req_lin,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_req_addr,
   input logic            done,
   input logic            fault,
   input logic [1:0]      fault_cause,
   input logic [PA_W-1:0] phys_addr
);
   logic [OFF_W-1:0] off_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      off_seen <= '0;
      else if (req_valid && req_ready) off_seen <= req_lin[OFF_W-1:0];
   end

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R9
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R9
   no_accept_while_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R10
   clean_success_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (fault_cause == 2'b00));

   // R3
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fault) |-> (phys_addr[OFF_W-1:0] == off_seen));
endmodule

bind pgw_walker pgw_walker_chk #(.LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_lin       (req_lin),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .fault         (fault),
   .fault_cause   (fault_cause),
   .phys_addr     (phys_addr)
);

// File: tb/pgw_walker_tb.sv
module pgw_walker_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_user;
   logic        req_ready;
   logic [31:0] req_lin, dir_base;
   logic        mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        done, fault, fault_level;
   logic [1:0]  fault_cause;
   logic [31:0] phys_addr;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_log [0:1023];
   int          nrd = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgw_walker u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
      .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
      .fault_cause(fault_cause), .fault_level(fault_level),
      .phys_addr(phys_addr)
   );

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // memory responder: one request at a time, random delays
   initial begin
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [31:0] a;
            repeat ($urandom_range(0, 2)) @(negedge clk);
            a = mem_req_addr;
            rd_log[nrd % 1024] = a;
            nrd++;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rdm(a);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // reference model built from the requirements
   task automatic model(input logic [31:0] lin, input bit wr, input bit us,
                        output bit e_f, output logic [1:0] e_c, output bit e_l,
                        output logic [31:0] e_pa, output int e_n,
                        output logic [31:0] e_a0, output logic [31:0] e_a1);
      logic [31:0] d, t;
      e_f = 0; e_c = 2'b00; e_l = 0; e_pa = 'x;
      e_a0 = {dir_base[31:12], lin[31:22], 2'b00};
      d = rdm(e_a0);
      e_n = 1; e_a1 = 'x;
      if (!d[0]) begin e_f = 1; e_c = 2'b01; return; end
      if (us && !d[2]) begin e_f = 1; e_c = 2'b11; return; end
      if (us && wr && !d[1]) begin e_f = 1; e_c = 2'b10; return; end
      e_a1 = {d[31:12], lin[21:12], 2'b00};
      t = rdm(e_a1);
      e_n = 2; e_l = 1;
      if (!t[0]) begin e_f = 1; e_c = 2'b01; return; end
      if (us && !(t[2] && d[2])) begin e_f = 1; e_c = 2'b11; return; end
      if (us && wr && !(t[1] && d[1])) begin e_f = 1; e_c = 2'b10; return; end
      e_l = 0; e_pa = {t[31:12], lin[11:0]};
   endtask

   task automatic walk(input logic [31:0] lin, input bit wr, input bit us);
      bit e_f, e_l;
      logic [1:0] e_c;
      logic [31:0] e_pa, e_a0, e_a1;
      int e_n, n0, cyc;
      model(lin, wr, us, e_f, e_c, e_l, e_pa, e_n, e_a0, e_a1);
      n0 = nrd;
      @(negedge clk);
      req_lin = lin; req_write = wr; req_user = us; req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 ready low during walk", req_ready, 0);
      // R9: scramble request inputs while busy
      req_lin = ~lin; req_write = ~wr; req_user = ~us;
      cyc = 0;
      while (!done && cyc < 100) begin @(negedge clk); cyc++; end
      req_valid = 1'b0;
      chk(done == 1'b1, "R10 done pulse seen", done, 1);
      chk(nrd - n0 == e_n, "R4 read count", nrd - n0, e_n);
      chk(rd_log[n0 % 1024] == e_a0, "R1 directory address", rd_log[n0 % 1024], e_a0);
      if (e_n == 2)
         chk(rd_log[(n0 + 1) % 1024] == e_a1, "R2 table address",
             rd_log[(n0 + 1) % 1024], e_a1);
      chk(fault == e_f, us ? "R6 R7 fault flag" : "R8 fault flag", fault, e_f);
      chk(fault_cause == e_c, e_l ? "R5 R6 R7 cause" : "R4 R6 R7 cause", fault_cause, e_c);
      if (e_f) chk(fault_level == e_l, "R4 R5 fault level", fault_level, e_l);
      else     chk(phys_addr == e_pa, "R3 physical address", phys_addr, e_pa);
      @(negedge clk);
      chk(done == 1'b0 && req_ready == 1'b1, "R10 done drops, ready back",
          {done, req_ready}, 2'b01);
   endtask

   // build a two-entry table set for lin
   task automatic setup(input logic [31:0] lin, input logic [31:0] d, input logic [31:0] t);
      mem.delete();
      mem[{dir_base[31:12], lin[31:22], 2'b00}] = d;
      if (d[0]) mem[{d[31:12], lin[21:12], 2'b00}] = t;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
      req_lin = '0; dir_base = 32'h0004_5000;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0,
          "R12 reset state", {req_ready, done, mem_req_valid}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req_valid == 1'b0, "R12 no read while idle", mem_req_valid, 0);

      // directed: full user write success (R3)
      setup(32'h1234_5678, 32'h0009_9007, 32'hABCD_E007);
      walk(32'h1234_5678, 1, 1);
      // top corner of the address space
      setup(32'hFFFF_FFFF, 32'hFFFF_F007, 32'hFFFF_F007);
      walk(32'hFFFF_FFFF, 1, 1);
      // directory absent (R4)
      setup(32'h0040_1000, 32'h0001_1006, 32'h0);
      walk(32'h0040_1000, 0, 0);
      // table absent (R5)
      setup(32'h0000_0ABC, 32'h0002_2007, 32'h0003_3006);
      walk(32'h0000_0ABC, 0, 1);
      // user refused at directory, also not writable (R6 priority)
      setup(32'h8000_0000, 32'h0002_2001, 32'h0003_3007);
      walk(32'h8000_0000, 1, 1);
      // user write refused at table only (R7)
      setup(32'h7654_3210, 32'h0002_2007, 32'h0003_3005);
      walk(32'h7654_3210, 1, 1);
      // user read of same mapping passes (R7 reads unaffected)
      walk(32'h7654_3210, 0, 1);
      // user refused only by table (R6 at level 1)
      setup(32'h0123_4000, 32'h0005_5007, 32'h0006_6003);
      walk(32'h0123_4000, 0, 1);
      // supervisor write through read-only, supervisor-only entries (R8)
      setup(32'h2468_ACE0, 32'h0007_7001, 32'h0008_8001);
      walk(32'h2468_ACE0, 1, 0);

      // constrained random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] lin, d, t;
         dir_base = {$urandom_range(0, 32'hFFFFF), 12'h0} ;
         lin = $urandom;
         d = {$urandom_range(0, 32'hFFFFF), 9'h0, ($urandom_range(0, 7) != 0),
              $urandom_range(0, 1) == 1 ? 2'b11 : 2'($urandom_range(0, 3))};
         d = {d[31:12], 9'h0, d[1], d[0], ($urandom_range(0, 7) != 0)};
         t = {$urandom_range(0, 32'hFFFFF), 9'h0, 1'($urandom_range(0, 3) != 0),
              1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) != 0)};
         setup(lin, d, t);
         walk(lin, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      summary();
   end
endmodule